// File: doc/BRIEF.md
# CAN Bit Timing Quantum Generator

This block turns a packed 16-bit timing word into the time base of a CAN controller. It divides the system clock into time quanta and groups those quanta into bits. Each bit has a single synchronization quantum, then a stretch of quanta before the sample point, then a stretch after it. Three one-clock pulses come out: a quantum tick, a sample-point pulse and an end-of-bit pulse. The last two each fall on the quantum tick that closes their segment.

The timing word is protected. A write changes it only while the controller is in initialization and configuration changes are enabled. While initialization is asserted, every counter stays at zero. When initialization is released, counting starts again from the beginning of the synchronization quantum. The resynchronization jump width field is stored and can be read back, but it has no effect on timing here. Edge resynchronization, stuffing and framing belong to other blocks.

Top module: `can_bit_timer`

## Requirements
- R1: After reset the stored timing word reads 0x2301, and the quantum tick, sample pulse and end-of-bit pulse are all low.
- R2: When `wr_en`, `init_mode` and `cfg_en` are all high at a rising clock edge, the word becomes `{0, wr_data[14:0]}`. The new value is visible on `timing_word` after that edge.
- R3: A write strobe has no effect on the stored word when `init_mode` is low or `cfg_en` is low.
- R4: Bit 15 of `timing_word` always reads 0.
- R5: Bits 5:0 of the word hold the prescaler value B. While `init_mode` is low, the quantum tick comes every 2*(B+1) clocks. This means a quantum lasts from 2 to 128 clocks.
- R6: While `init_mode` is high, no tick, sample pulse or end-of-bit pulse appears. After `init_mode` is sampled low at the first of a run of edges, the first tick appears 2*(B+1) edges later, and that tick closes the synchronization quantum.
- R7: Bits 11:8 hold T1 and bits 14:12 hold T2. A bit lasts T1+T2+3 quanta. The end-of-bit pulse rises together with the tick that closes the last quantum of each bit.
- R8: The sample pulse rises together with the tick that closes quantum number T1+2 of the bit, counting the synchronization quantum as number 1. It never coincides with the end-of-bit pulse.
- R9: The sample and end-of-bit pulses are each one clock wide, and each occurs only in a cycle where the quantum tick is high.
- R10: Bits 7:6 (the jump width, 0 to 3) are stored and read back, but they do not change the tick, sample or end-of-bit timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the timing word |
| wr_data | input | 16 | Timing word to be written |
| init_mode | input | 1 | Initialization mode; holds the counters at zero |
| cfg_en | input | 1 | Enables configuration changes |
| tq_tick | output | 1 | One-clock pulse at the end of each time quantum |
| sample_pulse | output | 1 | One-clock pulse at the sample point |
| bit_end_pulse | output | 1 | One-clock pulse at the end of each bit |
| timing_word | output | 16 | Readback of the stored timing word |

## Verification
The hardest situations to create are the timing extremes: the largest prescaler combined with the longest bit, and the shortest possible bit. In the shortest bit, the sample quantum sits directly before the closing quantum.

The stimulus sets up each case by loading the word while in initialization, then releasing initialization. It compares every following cycle against a quantum and bit position that the bench computes itself. Directed runs cover these extreme cases. Seeded random runs vary the prescaler, both segment lengths and the jump width. Between runs, write attempts are blocked by clearing one of the two enables, and the readback confirms that the word did not change.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  parameter int WORD_W = 16;
  parameter int BRP_W  = 6;
  parameter int SJW_W  = 2;
  parameter int TS1_W  = 4;
  parameter int TS2_W  = 3;
  parameter logic [WORD_W-1:0] WORD_RST = 16'h2301;

  typedef struct packed {
    logic             spare;
    logic [TS2_W-1:0] ts2;
    logic [TS1_W-1:0] ts1;
    logic [SJW_W-1:0] sjw;
    logic [BRP_W-1:0] brp;
  } bt_word_t;
endpackage

// File: rtl/bt_word_reg.sv
module bt_word_reg
  import can_bt_pkg::*;
#(
  parameter logic [WORD_W-1:0] RST_VAL = WORD_RST
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              init_mode,
  input  logic              cfg_en,
  output bt_word_t          word_q
);
  logic wr_ok;
  assign wr_ok = wr_en & init_mode & cfg_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= bt_word_t'({1'b0, RST_VAL[WORD_W-2:0]});
    end else if (wr_ok) begin
      word_q <= bt_word_t'({1'b0, wr_data[WORD_W-2:0]});
    end
  end
endmodule

// File: rtl/tq_prescaler.sv
module tq_prescaler #(
  parameter int BRP_W = 6,
  localparam int CNT_W = BRP_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic [BRP_W-1:0] brp,
  output logic             tq_due,
  output logic             tq_tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  // two system clocks per prescaler step: last count = 2*(brp+1)-1
  assign last   = {brp, 1'b1};
  assign tq_due = ~hold & (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      cnt     <= '0;
      tq_tick <= 1'b0;
    end else begin
      tq_tick <= tq_due;
      if (tq_due) cnt <= '0;
      else        cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bit_seg_seq.sv
module bit_seg_seq #(
  parameter int TS1_W = 4,
  parameter int TS2_W = 3,
  localparam int MAXQ   = (1 << TS1_W) + (1 << TS2_W) + 1,
  localparam int QCNT_W = $clog2(MAXQ)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             tq_due,
  input  logic [TS1_W-1:0] ts1,
  input  logic [TS2_W-1:0] ts2,
  output logic             sample_pulse,
  output logic             bit_end_pulse
);
  logic [QCNT_W-1:0] qidx;
  logic [QCNT_W-1:0] samp_idx;
  logic [QCNT_W-1:0] last_idx;
  logic              at_last;

  assign samp_idx = QCNT_W'(ts1) + QCNT_W'(1);
  assign last_idx = QCNT_W'(ts1) + QCNT_W'(ts2) + QCNT_W'(2);
  assign at_last  = (qidx == last_idx);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      qidx          <= '0;
      sample_pulse  <= 1'b0;
      bit_end_pulse <= 1'b0;
    end else if (tq_due) begin
      sample_pulse  <= (qidx == samp_idx);
      bit_end_pulse <= at_last;
      qidx          <= at_last ? '0 : qidx + 1'b1;
    end else begin
      sample_pulse  <= 1'b0;
      bit_end_pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import can_bt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              init_mode,
  input  logic              cfg_en,
  output logic              tq_tick,
  output logic              sample_pulse,
  output logic              bit_end_pulse,
  output logic [WORD_W-1:0] timing_word
);
  bt_word_t word;
  logic     tq_due;

  bt_word_reg #(.RST_VAL(WORD_RST)) u_word (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .init_mode(init_mode), .cfg_en(cfg_en), .word_q(word)
  );

  tq_prescaler #(.BRP_W(BRP_W)) u_presc (
    .clk(clk), .rst(rst), .hold(init_mode), .brp(word.brp),
    .tq_due(tq_due), .tq_tick(tq_tick)
  );

  bit_seg_seq #(.TS1_W(TS1_W), .TS2_W(TS2_W)) u_seq (
    .clk(clk), .rst(rst), .hold(init_mode), .tq_due(tq_due),
    .ts1(word.ts1), .ts2(word.ts2),
    .sample_pulse(sample_pulse), .bit_end_pulse(bit_end_pulse)
  );

  assign timing_word = word;
endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk
  import can_bt_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [WORD_W-1:0] wr_data,
  input logic              init_mode,
  input logic              cfg_en,
  input logic              tq_tick,
  input logic              sample_pulse,
  input logic              bit_end_pulse,
  input logic [WORD_W-1:0] timing_word
);
  // R2
  word_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && init_mode && cfg_en) |=> timing_word == {1'b0, $past(wr_data[WORD_W-2:0])});
  // R3
  word_locked_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && init_mode && cfg_en) |=> $stable(timing_word));
  // R4
  top_bit_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !timing_word[WORD_W-1]);
  // R5
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    tq_tick |=> !tq_tick);
  // R6
  init_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    init_mode |=> !tq_tick && !sample_pulse && !bit_end_pulse);
  // R8
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(sample_pulse && bit_end_pulse));
  // R9
  sample_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    sample_pulse |-> tq_tick);
  // R9
  end_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    bit_end_pulse |-> tq_tick);
  // R9
  sample_narrow_chk: assert property (@(posedge clk) disable iff (rst)
    sample_pulse |=> !sample_pulse);
endmodule

bind can_bit_timer can_bit_timer_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
  .init_mode(init_mode), .cfg_en(cfg_en), .tq_tick(tq_tick),
  .sample_pulse(sample_pulse), .bit_end_pulse(bit_end_pulse),
  .timing_word(timing_word)
);

// File: tb/can_bit_timer_test.sv
module can_bit_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        init_mode = 1'b1;
  logic        cfg_en = 1'b0;
  logic        tq_tick, sample_pulse, bit_end_pulse;
  logic [15:0] timing_word;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  can_bit_timer uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .init_mode(init_mode), .cfg_en(cfg_en), .tq_tick(tq_tick),
    .sample_pulse(sample_pulse), .bit_end_pulse(bit_end_pulse),
    .timing_word(timing_word)
  );

  function automatic logic [15:0] pack(int brp, int sjw, int t1, int t2);
    return {1'b0, 3'(t2), 4'(t1), 2'(sjw), 6'(brp)};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one strobe with the given enables; returns at a negedge after the edge
  task automatic write_word(logic [15:0] d, logic ini, logic cfg);
    @(negedge clk);
    wr_data = d; wr_en = 1'b1; init_mode = ini; cfg_en = cfg;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_bits(int brp, int sjw, int t1, int t2, int nbits);
    int per, nq, total, bad_t, bad_s, bad_e;
    int at, as_, ae, xt, xs, xe;
    logic [15:0] w;
    w = pack(brp, sjw, t1, t2);
    write_word(w, 1'b1, 1'b1);
    // R2 R10: stored including jump width
    check(timing_word == w, "R2/R10 readback", timing_word, w);
    @(negedge clk);
    init_mode = 1'b0; cfg_en = 1'b0;
    per = 2 * (brp + 1); nq = t1 + t2 + 3; total = per * nq * nbits + 3;
    bad_t = 0; bad_s = 0; bad_e = 0;
    at = 0; as_ = 0; ae = 0; xt = 0; xs = 0; xe = 0;
    for (int cyc = 1; cyc <= total; cyc++) begin
      int k;
      bit et, es, ee;
      @(negedge clk);
      et = (cyc % per) == 0;
      k  = cyc / per;
      es = et && (((k - 1) % nq) == t1 + 1);
      ee = et && (((k - 1) % nq) == nq - 1);
      if (tq_tick != et && bad_t == 0) begin at = tq_tick; xt = et; end
      if (sample_pulse != es && bad_s == 0) begin as_ = sample_pulse; xs = es; end
      if (bit_end_pulse != ee && bad_e == 0) begin ae = bit_end_pulse; xe = ee; end
      if (tq_tick != et) bad_t++;
      if (sample_pulse != es) bad_s++;
      if (bit_end_pulse != ee) bad_e++;
    end
    // R5 R6: tick cadence and first tick after init release
    check(bad_t == 0, "R5/R6 quantum tick", at, xt);
    // R8 R9: sample position
    check(bad_s == 0, "R8/R9 sample pulse", as_, xs);
    // R7 R9: bit length and end pulse
    check(bad_e == 0, "R7/R9 end-of-bit pulse", ae, xe);
    @(negedge clk);
    init_mode = 1'b1;
  endtask

  initial begin
    logic [15:0] held;
    int quiet;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(timing_word == 16'h2301, "R1 reset word", timing_word, 16'h2301);
    check({tq_tick, sample_pulse, bit_end_pulse} == 3'b000, "R1 outputs low",
          {tq_tick, sample_pulse, bit_end_pulse}, 0);
    // R6: init held, nothing ticks
    quiet = 0;
    repeat (20) begin @(negedge clk); quiet += tq_tick + sample_pulse + bit_end_pulse; end
    check(quiet == 0, "R6 init quiet", quiet, 0);
    // R3: cfg_en low blocks write
    held = timing_word;
    write_word(16'h7FFF, 1'b1, 1'b0);
    check(timing_word == held, "R3 blocked cfg low", timing_word, held);
    // R3: init low blocks write
    write_word(16'h1234, 1'b0, 1'b1);
    check(timing_word == held, "R3 blocked init low", timing_word, held);
    init_mode = 1'b1;
    // R4: bit 15 dropped
    write_word(16'hFFFF, 1'b1, 1'b1);
    check(timing_word == 16'h7FFF, "R4 top bit", timing_word, 16'h7FFF);
    // default word timing
    run_bits(1, 0, 3, 2, 3);
    // R7 R8: shortest bit
    run_bits(0, 3, 0, 0, 4);
    // longest quantum with longest bit
    run_bits(63, 1, 15, 7, 2);
    // R10: same timing with different jump widths
    run_bits(2, 0, 5, 3, 2);
    run_bits(2, 3, 5, 3, 2);
    // R6: init reasserted mid-bit, then quiet
    @(negedge clk); init_mode = 1'b0;
    repeat (7) @(negedge clk);
    init_mode = 1'b1;
    @(negedge clk);
    quiet = 0;
    repeat (30) begin @(negedge clk); quiet += tq_tick + sample_pulse + bit_end_pulse; end
    check(quiet == 0, "R6 init mid-bit quiet", quiet, 0);
    // random runs
    for (int i = 0; i < 12; i++) begin
      int b, s, a1, a2;
      b = $urandom_range(0, 9); s = $urandom_range(0, 3);
      a1 = $urandom_range(0, 15); a2 = $urandom_range(0, 7);
      run_bits(b, s, a1, a2, 2);
      // R3: blocked write between runs
      held = timing_word;
      write_word(16'($urandom), 1'b1, 1'b0);
      check(timing_word == held, "R3 random blocked", timing_word, held);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule